// File: doc/BRIEF.md
# Bootstrap Status and Write-Once Configuration Registers

This block holds two memory-mapped registers. The first is a device status word. It takes its value from a bus of external bootstrap pins while power-on reset is asserted. It keeps that value through every later hard reset until the next power-on reset. Software may change only two of its fields afterwards: the boot mode and the PCIe mode. The endianness flag, PCIe enable and PA clock select stay exactly as the pins set them.

The second register is a configuration word with one live bit, the system clock output enable. After each hard reset software can write it once. The first write locks it, and every later write is dropped without any error until the next hard reset. Both registers drive decoded control outputs directly, so downstream logic needs no register reads.

Access is through a simple synchronous port. Writes take effect at the clock edge where the write enable is sampled. Read data and its valid flag appear one cycle after the read request, with no wait states.

Top module: `bootcfg_regs`

## Requirements
- R1: While porRstN is low, the status register loads strapPins on every clock edge. Once porRstN is high it keeps the last value loaded, whatever the pins do. strapPins bit 0 is the little-endian flag, bits 13:1 the boot mode, bits 15:14 the PCIe mode, bit 16 the PCIe enable and bit 17 the PA clock select.
- R2: Reading byte offset 0x020 returns the status word, with the fields in the same bit positions as on strapPins and bits 31:18 reading 0.
- R3: A hard reset (hardRstN low, porRstN high) leaves every status field unchanged, including fields that software wrote.
- R4: A write to offset 0x020 updates the boot mode from data bits 13:1 and the PCIe mode from data bits 15:14. Data bits 0, 16, 17 and 31:18 have no effect.
- R5: The outputs reflect the stored status. littleEndian is 1 for little-endian and 0 for big-endian. pcieMode uses 00 for endpoint, 01 for legacy endpoint without MSI, 10 for root complex and 11 for reserved.
- R6: Either reset sets clkOutEn (configuration bit 0, offset 0x14C) to 1. Reading offset 0x14C returns clkOutEn in bit 0 and 0 in bits 31:1.
- R7: The first write to offset 0x14C after a reset stores data bit 0. Later writes to it are ignored until the next hard or power-on reset.
- R8: Reads of any other offset return 0, and writes to any other offset change neither register.
- R9: regRdValid is high in exactly the cycle after a cycle with regRdEn high. regRdData then holds the value the register had before any write in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, synchronous; samples straps |
| hardRstN | input | 1 | Hard reset, active low, synchronous |
| strapPins | input | 18 | Bootstrap pin values |
| regAddr | input | 12 | Byte offset of the access |
| regWrEn | input | 1 | Write request |
| regWrData | input | 32 | Write data |
| regRdEn | input | 1 | Read request |
| regRdData | output | 32 | Read data, valid with regRdValid |
| regRdValid | output | 1 | Read data valid, one cycle after regRdEn |
| littleEndian | output | 1 | 1 = little-endian, 0 = big-endian |
| bootMode | output | 13 | Boot mode field |
| pcieEnable | output | 1 | PCIe enable |
| pcieMode | output | 2 | PCIe mode code |
| paClkSel | output | 1 | PA clock reference select |
| clkOutEn | output | 1 | System clock output enable |

## Verification
The bench changes the strap bus during and after power-on reset. This shows whether the status register takes the last value sampled in reset or follows the pins afterwards. The status register is written with every data bit set, which separates the writable fields from the read-only and reserved bits. The configuration register gets a pair of opposite writes, both before and after a lone hard reset, which exposes a missing lock or a lock that does not clear. Unmapped accesses, a second power-on reset with the opposite endianness, and a read issued in the same cycle as a write cover address decoding, re-capture and read ordering.

// File: rtl/bootcfg_pkg.sv
package bootcfg_pkg;
  localparam logic [1:0] SEL_NONE = 2'd0;
  localparam logic [1:0] SEL_STS  = 2'd1;
  localparam logic [1:0] SEL_CFG  = 2'd2;

  typedef struct packed {
    logic       stsWr;
    logic       cfgWr;
    logic       rdReq;
    logic [1:0] rdSel;
  } regStrobe_t;
endpackage

// File: rtl/bootcfg_ctrl.sv
module bootcfg_ctrl
  import bootcfg_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int STS_OFS = 'h020,
  parameter int CFG_OFS = 'h14C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  output regStrobe_t        strb,
  output logic              regRdValid,
  output logic              cfgLocked
);
  localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_OFS);
  localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_OFS);

  logic hitSts, hitCfg;

  always_comb begin
    hitSts     = (regAddr == STS_A);
    hitCfg     = (regAddr == CFG_A);
    strb.stsWr = rstN & regWrEn & hitSts;
    strb.cfgWr = rstN & regWrEn & hitCfg & ~cfgLocked;
    strb.rdReq = rstN & regRdEn;
    if (hitSts)      strb.rdSel = SEL_STS;
    else if (hitCfg) strb.rdSel = SEL_CFG;
    else             strb.rdSel = SEL_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgLocked  <= 1'b0;
      regRdValid <= 1'b0;
    end else begin
      if (regWrEn && hitCfg) cfgLocked <= 1'b1;
      regRdValid <= regRdEn;
    end
  end

  // R9
  rd_valid_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> regRdValid);
  // R9
  rd_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |=> !regRdValid);
endmodule

// File: rtl/bootcfg_dpath.sv
module bootcfg_dpath
  import bootcfg_pkg::*;
#(
  parameter int BOOT_W = 13,
  parameter int DATA_W = 32,
  localparam int STRAP_W = BOOT_W + 5
) (
  input  logic               clk,
  input  logic               porRstN,
  input  logic               rstN,
  input  logic [STRAP_W-1:0] strapPins,
  input  regStrobe_t         strb,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               littleEndian,
  output logic [BOOT_W-1:0]  bootMode,
  output logic               pcieEnable,
  output logic [1:0]         pcieMode,
  output logic               paClkSel,
  output logic               clkOutEn
);
  localparam int BOOT_LO = 1;
  localparam int BOOT_HI = BOOT_W;
  localparam int MODE_LO = BOOT_W + 1;
  localparam int MODE_HI = BOOT_W + 2;
  localparam int EN_BIT  = BOOT_W + 3;
  localparam int PA_BIT  = BOOT_W + 4;

  logic [DATA_W-1:0] stsWord, cfgWord, rdMux;
  logic unusedWrHi;
  assign unusedWrHi = ^regWrData[DATA_W-1:MODE_HI+1];

  // status: captured only by power-on reset
  always_ff @(posedge clk) begin
    if (!porRstN) begin
      littleEndian <= strapPins[0];
      bootMode     <= strapPins[BOOT_HI:BOOT_LO];
      pcieMode     <= strapPins[MODE_HI:MODE_LO];
      pcieEnable   <= strapPins[EN_BIT];
      paClkSel     <= strapPins[PA_BIT];
    end else if (strb.stsWr) begin
      bootMode <= regWrData[BOOT_HI:BOOT_LO];
      pcieMode <= regWrData[MODE_HI:MODE_LO];
    end
  end

  // configuration: cleared by any reset
  always_ff @(posedge clk) begin
    if (!rstN)           clkOutEn <= 1'b1;
    else if (strb.cfgWr) clkOutEn <= regWrData[0];
  end

  always_comb begin
    stsWord                  = '0;
    stsWord[0]               = littleEndian;
    stsWord[BOOT_HI:BOOT_LO] = bootMode;
    stsWord[MODE_HI:MODE_LO] = pcieMode;
    stsWord[EN_BIT]          = pcieEnable;
    stsWord[PA_BIT]          = paClkSel;
    cfgWord                  = '0;
    cfgWord[0]               = clkOutEn;
    case (strb.rdSel)
      SEL_STS: rdMux = stsWord;
      SEL_CFG: rdMux = cfgWord;
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)           regRdData <= '0;
    else if (strb.rdReq) regRdData <= rdMux;
  end

  // R1
  strap_hold_chk: assert property (@(posedge clk) disable iff (!porRstN)
    porRstN |=> $stable(littleEndian) && $stable(pcieEnable) && $stable(paClkSel));
  // R3
  sts_keep_on_hard_chk: assert property (@(posedge clk) disable iff (!porRstN)
    !rstN |=> $stable(bootMode) && $stable(pcieMode));
  // R6
  cfg_default_chk: assert property (@(posedge clk) disable iff (!porRstN)
    !rstN |=> clkOutEn);
endmodule

// File: rtl/bootcfg_regs.sv
module bootcfg_regs
  import bootcfg_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int BOOT_W  = 13,
  parameter int STS_OFS = 'h020,
  parameter int CFG_OFS = 'h14C
) (
  input  logic                clk,
  input  logic                porRstN,
  input  logic                hardRstN,
  input  logic [BOOT_W+4:0]   strapPins,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [DATA_W-1:0]   regWrData,
  input  logic                regRdEn,
  output logic [DATA_W-1:0]   regRdData,
  output logic                regRdValid,
  output logic                littleEndian,
  output logic [BOOT_W-1:0]   bootMode,
  output logic                pcieEnable,
  output logic [1:0]          pcieMode,
  output logic                paClkSel,
  output logic                clkOutEn
);
  logic       sysRstN;
  logic       cfgLocked;
  regStrobe_t strb;

  assign sysRstN = porRstN & hardRstN;

  bootcfg_ctrl #(
    .ADDR_W(ADDR_W), .STS_OFS(STS_OFS), .CFG_OFS(CFG_OFS)
  ) uCtrl (
    .clk(clk), .rstN(sysRstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .strb(strb), .regRdValid(regRdValid),
    .cfgLocked(cfgLocked)
  );

  bootcfg_dpath #(
    .BOOT_W(BOOT_W), .DATA_W(DATA_W)
  ) uDpath (
    .clk(clk), .porRstN(porRstN), .rstN(sysRstN), .strapPins(strapPins),
    .strb(strb), .regWrData(regWrData), .regRdData(regRdData),
    .littleEndian(littleEndian), .bootMode(bootMode), .pcieEnable(pcieEnable),
    .pcieMode(pcieMode), .paClkSel(paClkSel), .clkOutEn(clkOutEn)
  );

  // R7
  cfg_lock_hold_chk: assert property (@(posedge clk) disable iff (!sysRstN)
    cfgLocked |=> $stable(clkOutEn));
endmodule

// File: tb/sim_bootcfg_regs.sv
`timescale 1ns/1ps
module sim_bootcfg_regs;
  logic        clk = 1'b0;
  logic        porRstN = 1'b0, hardRstN = 1'b0;
  logic [17:0] strapPins = '0;
  logic [11:0] regAddr = '0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        regRdValid, littleEndian, pcieEnable, paClkSel, clkOutEn;
  logic [12:0] bootMode;
  logic [1:0]  pcieMode;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;

  bootcfg_regs u0 (.*);

  function automatic logic [31:0] mkSts(logic pa, logic en, logic [1:0] md,
                                        logic [12:0] bm, logic le);
    return {14'b0, pa, en, md, bm, le};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as valid results appear
  always @(negedge clk) begin
    if (regRdValid) begin
      if (expQ.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL R9 unexpected valid actual=%h expected=none", regRdData);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(t, regRdData, e);
      end
    end
  end

  task automatic doRead(logic [11:0] a, logic [31:0] e, string t);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    expQ.push_back(e); tagQ.push_back(t);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic doWrite(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog (all R) actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] s1, s1w, s2, s2w, wAll;
    s1 = mkSts(1'b1, 1'b1, 2'b10, 13'h0A5, 1'b1);
    s2 = mkSts(1'b0, 1'b0, 2'b01, 13'h0F0F, 1'b0);
    // power-on reset, straps change mid-reset; last value must stick
    strapPins = 18'h155AA;
    repeat (2) @(negedge clk);
    strapPins = s1[17:0];
    repeat (2) @(negedge clk);
    porRstN = 1'b1; hardRstN = 1'b1;
    strapPins = 18'h3FFFF;
    repeat (3) @(negedge clk);
    chk("R6 reset clkOutEn", {31'b0, clkOutEn}, 32'd1);
    chk("R9 reset rdValid", {31'b0, regRdValid}, 32'd0);
    chk("R1 held status", {14'b0, paClkSel, pcieEnable, pcieMode, bootMode, littleEndian}, s1);
    chk("R5 littleEndian=1", {31'b0, littleEndian}, 32'd1);
    chk("R5 pcieMode root complex", {30'b0, pcieMode}, 32'd2);
    doRead(12'h020, s1, "R2 status read");
    doRead(12'h14C, 32'd1, "R6 config read");

    // R4: write all ones, only boot mode and pcie mode move
    wAll = 32'hFFFF_FFFF;
    doWrite(12'h020, wAll);
    s1w = mkSts(1'b1, 1'b1, 2'b11, 13'h1FFF, 1'b1);
    doRead(12'h020, s1w, "R4 status after write");
    chk("R4 bootMode", {19'b0, bootMode}, 32'h1FFF);

    // R7: first config write wins, second dropped
    doWrite(12'h14C, 32'h0);
    chk("R7 first write", {31'b0, clkOutEn}, 32'd0);
    doWrite(12'h14C, 32'hFFFF_FFFF);
    chk("R7 locked write", {31'b0, clkOutEn}, 32'd0);
    doRead(12'h14C, 32'd0, "R7 config read locked");

    // R8: unmapped offsets
    doWrite(12'h024, 32'hFFFF_FFFF);
    doWrite(12'h14D, 32'hFFFF_FFFF);
    doRead(12'h024, 32'd0, "R8 unmapped read");
    doRead(12'h020, s1w, "R8 status unchanged");
    doRead(12'h14C, 32'd0, "R8 config unchanged");

    // R3: hard reset alone with new straps
    @(negedge clk);
    strapPins = s2[17:0]; hardRstN = 1'b0;
    repeat (2) @(negedge clk);
    hardRstN = 1'b1;
    @(negedge clk);
    doRead(12'h020, s1w, "R3 status kept over hard reset");
    chk("R6 clkOutEn after hard reset", {31'b0, clkOutEn}, 32'd1);
    doWrite(12'h14C, 32'h0);
    chk("R7 lock cleared by hard reset", {31'b0, clkOutEn}, 32'd0);
    doWrite(12'h14C, 32'h1);
    chk("R7 relocked", {31'b0, clkOutEn}, 32'd0);

    // second power-on reset: big-endian straps
    @(negedge clk);
    porRstN = 1'b0; hardRstN = 1'b0;
    repeat (2) @(negedge clk);
    porRstN = 1'b1; hardRstN = 1'b1;
    strapPins = '0;
    @(negedge clk);
    chk("R5 littleEndian=0 big", {31'b0, littleEndian}, 32'd0);
    chk("R5 pcieMode legacy", {30'b0, pcieMode}, 32'd1);
    chk("R6 clkOutEn after por", {31'b0, clkOutEn}, 32'd1);
    doRead(12'h020, s2, "R1 recapture");

    // R9: read in the same cycle as a status write returns old value
    s2w = mkSts(1'b0, 1'b0, 2'b00, 13'h0001, 1'b0);
    @(negedge clk);
    regAddr = 12'h020; regRdEn = 1'b1; regWrEn = 1'b1;
    regWrData = mkSts(1'b1, 1'b1, 2'b00, 13'h0001, 1'b1) | 32'hFFFC_0000;
    expQ.push_back(s2); tagQ.push_back("R9 read before write");
    @(negedge clk);
    regRdEn = 1'b0; regWrEn = 1'b0;
    doRead(12'h020, s2w, "R4 R9 read after write");
    repeat (3) @(negedge clk);
    chk("R9 all reads returned", expQ.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule